// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock-line timing for an I2C controller from a fast peripheral clock. A packed divider word holds two fields. The low field sets a prescaler, which divides the peripheral clock by (1 + prescale) to make an internal tick. The upper 6-bit field, called the period step below, sets each SCL half period to 10 + 4·step internal ticks. A full period is therefore 20 + 8·step ticks plus the time the line takes to rise. Choose the prescale value so that the internal tick rate stays below 20 MHz.

The generator pulls SCL low for the low half. It then releases the line and does not start counting the high half until the sampled line reads high. Slow rise times and targets that hold the clock low therefore stretch the period without extra logic. Two strobes pace the byte engine: one marks the middle of the low half, where SDA may change, and one marks the middle of the high half, where SDA is sampled. On a start request the block first waits a programmable number of peripheral cycles (setup code + 2, so code 15 gives 17 cycles) with SCL still released, before the first low half. The configuration is captured when a run starts.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and whenever idle, scl_drive_low, both strobes, int_tick, setup_active and busy are 0.
- R2: During a low or high half, int_tick pulses once every (1 + prescale) peripheral cycles, first in the (1 + prescale)-th cycle of the half. It never pulses outside a half.
- R3: The divider word is decoded with prescale = div_cfg[CDF_W-1:0] and step = div_cfg[CDF_W+5:CDF_W]. For example, with CDF_W=3, word 26 gives a 66-cycle low half and word 505 gives a 524-cycle low half.
- R4: Each low half lasts exactly (10 + 4·step)·(1 + prescale) peripheral cycles. A low half is entered only from the setup wait or from the end of a high half.
- R5: After a low half the line is released. The high half begins the cycle after scl_in is sampled high and lasts (10 + 4·step)·(1 + prescale) cycles.
- R6: When run is raised while idle, setup_active is 1 and SCL stays released for setup_cfg + 2 cycles. The first low half follows immediately.
- R7: sda_change_stb pulses once per low half, in its (5 + 2·step)·(1 + prescale)-th cycle.
- R8: sda_sample_stb pulses once per high half, in its (5 + 2·step)·(1 + prescale)-th cycle.
- R9: If run is 0 while the block waits for the released line, it returns to idle with SCL released. Changes to div_cfg or setup_cfg while busy have no effect until the next start.
- R10: The two strobes are never high together, and sda_change_stb only occurs while SCL is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start and keep generating clock periods |
| div_cfg | input | CDF_W+6 | Packed word: step in the upper bits, prescale in the low CDF_W bits |
| setup_cfg | input | SETUP_W | First-bit setup code; wait = code + 2 cycles |
| scl_in | input | 1 | Synchronised sample of the SCL line |
| scl_drive_low | output | 1 | 1 = pull SCL low |
| sda_change_stb | output | 1 | One-cycle pulse at the middle of the low half |
| sda_sample_stb | output | 1 | One-cycle pulse at the middle of the high half |
| int_tick | output | 1 | Internal clock enable |
| setup_active | output | 1 | First-bit setup wait in progress |
| busy | output | 1 | Not idle |

## Verification
Every cycle, the assertions check the local rules:
- the change strobe falls inside the low half, and each strobe is a single pulse;
- a high half starts only after the line was seen high;
- a low half is entered only from the setup wait or after a high half;
- the tick never repeats on back-to-back cycles when dividing;
- the captured configuration stays fixed while busy;
- the block drops to idle only from the release wait with run low.

Exact half-period lengths, strobe positions, field decoding and the setup length depend on counted windows. Only the bench's cycle model shows these, across several prescale and step values, slow-rise stretching and a configuration change made mid-run.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  localparam int STEP_W = 6;
  localparam int TICK_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_LOW     = 3'd2,
    ST_WAIT_HI = 3'd3,
    ST_HIGH    = 3'd4
  } scl_state_e;

  // ticks in one half period: 10 + 4*step
  function automatic logic [TICK_W-1:0] half_period_ticks(input logic [STEP_W-1:0] step);
    return TICK_W'(10) + {1'b0, step, 2'b00};
  endfunction

  // tick index (1-based) of the mid-phase strobe: 5 + 2*step
  function automatic logic [TICK_W-1:0] mid_phase_ticks(input logic [STEP_W-1:0] step);
    return TICK_W'(5) + {2'b00, step, 1'b0};
  endfunction

endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int CDF_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CDF_W-1:0] prescale,
  output logic             tick
);

  logic [CDF_W-1:0] pre_cnt;

  assign tick = en && (pre_cnt == prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_cnt <= '0;
    else if (!en)     pre_cnt <= '0;
    else if (tick)    pre_cnt <= '0;
    else              pre_cnt <= pre_cnt + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (prescale != '0) && $stable(prescale)) |=> !tick);

endmodule

// File: rtl/scl_setup_timer.sv
module scl_setup_timer #(
  parameter int SETUP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SETUP_W-1:0] code,
  output logic               active,
  output logic               done
);

  localparam int CNT_W = SETUP_W + 1;

  logic [CNT_W-1:0] remain;

  assign done = active && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
    end else if (load) begin
      active <= 1'b1;
      remain <= {1'b0, code} + CNT_W'(1);
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  // R6
  setup_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !active);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              scl_in,
  input  logic              tick,
  input  logic              setup_done,
  input  logic [STEP_W-1:0] step,
  output logic              start,
  output logic              tick_en,
  output logic              scl_drive_low,
  output logic              sda_change_stb,
  output logic              sda_sample_stb,
  output logic              busy
);

  scl_state_e        state, state_nxt;
  logic [TICK_W-1:0] ph_cnt;
  logic [TICK_W-1:0] end_idx, mid_idx;
  logic              in_low, in_high;
  logic              low_end, high_end;
  logic              mid_low, mid_high;
  logic              enter_high;

  assign end_idx  = half_period_ticks(step) - TICK_W'(1);
  assign mid_idx  = mid_phase_ticks(step) - TICK_W'(1);
  assign in_low   = (state == ST_LOW);
  assign in_high  = (state == ST_HIGH);
  assign low_end  = in_low  && tick && (ph_cnt == end_idx);
  assign high_end = in_high && tick && (ph_cnt == end_idx);
  assign mid_low  = in_low  && tick && (ph_cnt == mid_idx);
  assign mid_high = in_high && tick && (ph_cnt == mid_idx);
  assign enter_high = (state == ST_WAIT_HI) && run && scl_in;

  assign start          = (state == ST_IDLE) && run;
  assign tick_en        = in_low || in_high;
  assign scl_drive_low  = in_low;
  assign sda_change_stb = mid_low;
  assign sda_sample_stb = mid_high;
  assign busy           = (state != ST_IDLE);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:    if (run) state_nxt = ST_SETUP;
      ST_SETUP:   if (setup_done) state_nxt = ST_LOW;
      ST_LOW:     if (low_end) state_nxt = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (!run)         state_nxt = ST_IDLE;
        else if (scl_in)  state_nxt = ST_HIGH;
      end
      ST_HIGH:    if (high_end) state_nxt = ST_LOW;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ph_cnt <= '0;
    else if (!tick_en)           ph_cnt <= '0;
    else if (low_end || high_end) ph_cnt <= '0;
    else if (tick)               ph_cnt <= ph_cnt + 1'b1;
  end

  // R10
  change_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |-> scl_drive_low);

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_change_stb && sda_sample_stb));

  // R5
  high_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high && $past(state) == ST_WAIT_HI) |-> $past(scl_in));

  // R4
  low_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> ($past(state) == ST_SETUP || $past(state) == ST_HIGH));

  // R9
  stop_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(state) == ST_WAIT_HI && !$past(run) && !scl_drive_low));

  // R7
  change_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |=> !sda_change_stb);

  // R8
  sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_stb |=> !sda_sample_stb);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int CDF_W   = 3,
  parameter int SETUP_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [CDF_W+STEP_W-1:0] div_cfg,
  input  logic [SETUP_W-1:0]      setup_cfg,
  input  logic                    scl_in,
  output logic                    scl_drive_low,
  output logic                    sda_change_stb,
  output logic                    sda_sample_stb,
  output logic                    int_tick,
  output logic                    setup_active,
  output logic                    busy
);

  localparam int CFG_W = CDF_W + STEP_W;

  logic [CDF_W-1:0]  prescale_q;
  logic [STEP_W-1:0] step_q;
  logic              start, tick_en, setup_done;

  // capture the divider word at start; held for the whole run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale_q <= '0;
      step_q     <= '0;
    end else if (start) begin
      prescale_q <= div_cfg[CDF_W-1:0];
      step_q     <= div_cfg[CFG_W-1:CDF_W];
    end
  end

  scl_tick_div #(.CDF_W(CDF_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tick_en),
    .prescale (prescale_q),
    .tick     (int_tick)
  );

  scl_setup_timer #(.SETUP_W(SETUP_W)) u_setup (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .code   (setup_cfg),
    .active (setup_active),
    .done   (setup_done)
  );

  scl_phase_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .run            (run),
    .scl_in         (scl_in),
    .tick           (int_tick),
    .setup_done     (setup_done),
    .step           (step_q),
    .start          (start),
    .tick_en        (tick_en),
    .scl_drive_low  (scl_drive_low),
    .sda_change_stb (sda_change_stb),
    .sda_sample_stb (sda_sample_stb),
    .busy           (busy)
  );

  // R6
  setup_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_active |-> (!scl_drive_low && !int_tick));

  // R9
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(prescale_q) && $stable(step_q)));

endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

  localparam int CDF_W   = 3;
  localparam int SETUP_W = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                run = 1'b0;
  logic [CDF_W+5:0]    div_cfg = '0;
  logic [SETUP_W-1:0]  setup_cfg = '0;
  logic                scl_in = 1'b1;
  logic                scl_drive_low, sda_change_stb, sda_sample_stb;
  logic                int_tick, setup_active, busy;

  int n_checks = 0;
  int n_fail   = 0;
  int rise_dly = 0;
  int rel_cnt  = 100;

  // reference model state
  int m = 0;        // 0 idle, 1 setup, 2 low, 3 wait line, 4 high
  int cnt = 0;
  int d = 1, half = 10, mid = 5, setup_n = 2;
  int cur_low = 0, last_low = 0;

  always #5 clk = ~clk;

  scl_timing_gen #(.CDF_W(CDF_W), .SETUP_W(SETUP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_cfg(div_cfg), .setup_cfg(setup_cfg),
    .scl_in(scl_in), .scl_drive_low(scl_drive_low), .sda_change_stb(sda_change_stb),
    .sda_sample_stb(sda_sample_stb), .int_tick(int_tick),
    .setup_active(setup_active), .busy(busy)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // bus model: line follows the drive, rising rise_dly cycles late
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scl_drive_low) begin
        rel_cnt = 0;
        scl_in  = 1'b0;
      end else begin
        rel_cnt++;
        scl_in = (rel_cnt > rise_dly);
      end
    end
  end

  // cycle model and comparison
  always @(negedge clk) begin
    bit e_low, e_tick, e_chg, e_smp;
    string tag;
    if (!rst_n) m = 0;
    e_low  = (m == 2);
    e_tick = (m == 2 || m == 4) && ((cnt % d) == d - 1);
    e_chg  = (m == 2) && (cnt == mid * d - 1);
    e_smp  = (m == 4) && (cnt == mid * d - 1);
    case (m)
      0: tag = "R1";
      1: tag = "R6";
      2: tag = "R4";
      3: tag = "R9";
      default: tag = "R5";
    endcase
    chk(tag, "scl_drive_low", int'(scl_drive_low), int'(e_low));
    chk((m == 0) ? "R1" : "R2", "int_tick", int'(int_tick), int'(e_tick));
    chk("R7", "sda_change_stb", int'(sda_change_stb), int'(e_chg));
    chk("R8", "sda_sample_stb", int'(sda_sample_stb), int'(e_smp));
    chk("R6", "setup_active", int'(setup_active), int'(m == 1));
    chk((m == 3) ? "R9" : "R1", "busy", int'(busy), int'(m != 0));
    chk("R10", "strobe overlap", int'(sda_change_stb && (sda_sample_stb || !scl_drive_low)), 0);
    if (scl_drive_low) cur_low++;
    else if (cur_low > 0) begin last_low = cur_low; cur_low = 0; end
    if (rst_n) begin
      case (m)
        0: if (run) begin
             d       = (div_cfg % (1 << CDF_W)) + 1;
             half    = 10 + 4 * (div_cfg / (1 << CDF_W));
             mid     = half / 2;
             setup_n = setup_cfg + 2;
             m = 1; cnt = 0;
           end
        1: if (cnt == setup_n - 1) begin m = 2; cnt = 0; end else cnt++;
        2: if (cnt == half * d - 1) begin m = 3; cnt = 0; end else cnt++;
        3: begin
             if (!run) m = 0;
             else if (scl_in) m = 4;
             cnt = 0;
           end
        default: if (cnt == half * d - 1) begin m = 2; cnt = 0; end else cnt++;
      endcase
    end
  end

  task automatic burst(input int cfg, input int setup, input int rise, input int cycles,
                       input int cfg_mid);
    @(posedge clk); #1;
    div_cfg   = cfg[CDF_W+5:0];
    setup_cfg = setup[SETUP_W-1:0];
    rise_dly  = rise;
    run       = 1'b1;
    repeat (cycles / 2) @(posedge clk);
    #1;
    if (cfg_mid >= 0) begin
      div_cfg   = cfg_mid[CDF_W+5:0];
      setup_cfg = '0;
    end
    repeat (cycles - cycles / 2) @(posedge clk);
    #1 run = 1'b0;
    while (busy) @(posedge clk);
    repeat (5) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1 idle state after reset, observed at the ports
    @(negedge clk);
    chk("R1", "idle outputs", int'({scl_drive_low, sda_change_stb, sda_sample_stb,
                                    int_tick, setup_active, busy}), 0);
    // fastest setting, 17-cycle setup
    burst(0, 15, 0, 90, -1);
    // prescale 2, step 3, slow rise
    burst((3 << CDF_W) | 2, 0, 3, 300, -1);
    chk("R3", "low half length for word 26", last_low, 66);
    // prescale 7, step 1, long stretch, configuration rewritten mid-run
    burst((1 << CDF_W) | 7, 5, 40, 420, 0);
    chk("R9", "low half after mid-run rewrite", last_low, 14 * 8);
    // prescale 1, largest step
    burst((63 << CDF_W) | 1, 15, 1, 1200, -1);
    chk("R3", "low half length for word 505", last_low, 524);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule